// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Data-Retention Sequencing

This block sits between a synchronous host and an asynchronous static RAM of 131072 bytes. The RAM has a 17-bit address, a bidirectional 8-bit data bus and four control pins: an active-low select, an active-high select, an active-low write strobe and an active-low output enable. The host offers one read or one write at a time with a valid/ready handshake. The controller registers the address and write data, then holds the RAM pins in the right pattern for a fixed number of clocks. `CYC_CLKS` sets that count to match the RAM speed grade, for example 8 clocks for a 30 ns part at 250 MHz. Read data comes back with a one-clock valid pulse.

The host can also hold a level request to put the RAM into a low-power data-retention state. The controller enters that state only from idle. It then drives the active-high select low and the active-low select high, keeps the output enable and write strobe inactive, and refuses accesses. When the request drops, the controller stays deselected for one full cycle time of recovery before it accepts work again.

The state machine has five states:
- `ST_IDLE`: deselected and ready.
- `ST_READ`: selected, output enable low.
- `ST_WRITE`: selected, with the write strobe pulsed in the middle of the cycle.
- `ST_RETAIN`: held in data retention.
- `ST_RECOVER`: deselected while the recovery time runs.

The transitions are:
- IDLE→RETAIN when the retention request is high. This has priority over an access.
- IDLE→READ or IDLE→WRITE on an accepted request.
- READ→IDLE and WRITE→IDLE on the last clock of the cycle.
- RETAIN→RECOVER when the request drops.
- RECOVER→IDLE after `CYC_CLKS` clocks.

Top module: `sram_ret_ctrl`

## Requirements
- R1: After reset the controller is idle: `mem_cs1_n`=1, `mem_cs2`=1, `mem_we_n`=1, `mem_oe_n`=1, `rd_valid`=0, and `req_ready`=1 while `ret_req` is low.
- R2: A read keeps `mem_cs1_n`=0, `mem_cs2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly `CYC_CLKS` clocks. The bus is sampled on the last of those clocks. On the following clock `rd_valid` is 1 for one clock with that byte on `rd_data`.
- R3: A write keeps the RAM selected with `mem_oe_n`=1 for exactly `CYC_CLKS` clocks. `mem_we_n` is low for the `CYC_CLKS`-2 middle clocks and high on the first and last.
- R4: `mem_addr` is the registered request address and stays stable for the whole access, whatever the host address inputs do after acceptance.
- R5: `req_ready` is 0 in every state other than idle, so requests made during an access, retention or recovery are held off and do not reach the pins.
- R6: While retention is held, `mem_cs2`=0, `mem_cs1_n`=1, `mem_oe_n`=1 and `mem_we_n`=1.
- R7: After `ret_req` falls, the controller stays deselected with `req_ready`=0 for exactly `CYC_CLKS` clocks, then returns to idle. Memory contents are undisturbed.
- R8: In idle, `ret_req` high forces `req_ready` to 0, so a retention request wins over a simultaneous access.
- R9: The controller drives `mem_dq` only while `mem_we_n` is low, and what it drives is the registered write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Controller can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Access address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 8 | Read data |
| ret_req | input | 1 | Level request for data retention |
| mem_addr | output | 17 | RAM address |
| mem_dq | inout | 8 | RAM data bus |
| mem_cs1_n | output | 1 | RAM select, active low |
| mem_cs2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
Writes and reads use all-zero, all-one and mixed address and data patterns. These patterns separate stuck or swapped address and data bits from correct routing. The host address is scrambled straight after acceptance, which separates a registered address from a pass-through one. Strobe windows are measured clock by clock, which tells a correct cycle length and write-strobe placement from off-by-one sequencing. Retention is exercised three ways: alone, with access requests held against it, and raised together with a request. Data is read back afterwards, so the tests can tell held-off accesses, the recovery length and the retention priority from leaks through the handshake.

// File: rtl/sram_ret_pkg.sv
package sram_ret_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RETAIN,
        ST_RECOVER
    } ctl_state_e;
endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int CYC_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic first,
    output logic last
);
    localparam int CNT_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
    localparam logic [CNT_W-1:0] TOP = CNT_W'(CYC_CLKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= TOP;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign first = (cnt == TOP);
    assign last  = (cnt == '0);
endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drv_en,
    input  logic              rd_cap,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    inout  wire  [DATA_W-1:0] mem_dq
);
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (capture) begin
                mem_addr <= req_addr;
                wdata_q  <= req_wdata;
            end
            rd_valid <= rd_cap;
            if (rd_cap) begin
                rd_data <= mem_dq;
            end
        end
    end

    assign mem_dq = drv_en ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_ret_ctrl.sv
module sram_ret_ctrl
    import sram_ret_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CYC_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ret_req,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n
);
    ctl_state_e state, state_nx;
    logic       accept;
    logic       t_load;
    logic       t_first;
    logic       t_last;
    logic       drv_en;
    logic       rd_cap;

    assign req_ready = (state == ST_IDLE) && !ret_req;
    assign accept    = req_valid && req_ready;
    assign t_load    = accept || ((state == ST_RETAIN) && !ret_req);

    sram_cyc_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .first (t_first),
        .last  (t_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ret_req)     state_nx = ST_RETAIN;
                else if (accept) state_nx = req_write ? ST_WRITE : ST_READ;
            end
            ST_READ:    if (t_last)   state_nx = ST_IDLE;
            ST_WRITE:   if (t_last)   state_nx = ST_IDLE;
            ST_RETAIN:  if (!ret_req) state_nx = ST_RECOVER;
            ST_RECOVER: if (t_last)   state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        mem_cs1_n = 1'b1;
        mem_cs2   = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        drv_en    = 1'b0;
        rd_cap    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_READ: begin
                mem_cs1_n = 1'b0;
                mem_oe_n  = 1'b0;
                rd_cap    = t_last;
            end
            ST_WRITE: begin
                mem_cs1_n = 1'b0;
                mem_we_n  = t_first || t_last;
                drv_en    = !(t_first || t_last);
            end
            ST_RETAIN, ST_RECOVER: begin
                mem_cs2 = 1'b0;
            end
            default: ;
        endcase
    end

    sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .drv_en    (drv_en),
        .rd_cap    (rd_cap),
        .mem_addr  (mem_addr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .mem_dq    (mem_dq)
    );
endmodule

// File: rtl/sram_ret_ctrl_chk.sv
module sram_ret_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              ret_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              drv_en
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_cs1_n && mem_cs2 && mem_we_n && mem_oe_n && !rd_valid));

    p_read_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && mem_cs2 && !mem_oe_n) |-> mem_we_n);

    p_rdv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_we_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr));

    p_busy_noready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs1_n |-> !req_ready);

    p_ret_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs2 |-> (mem_cs1_n && mem_oe_n && mem_we_n && !req_ready));

    p_recover_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs2 && !ret_req) |-> mem_cs1_n);

    p_ret_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |-> !req_ready);

    p_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!mem_we_n && !mem_cs1_n && mem_cs2));
endmodule

bind sram_ret_ctrl sram_ret_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .ret_req   (ret_req),
    .mem_addr  (mem_addr),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .drv_en    (drv_en)
);

// File: tb/sram_ret_ctrl_tb.sv
module sram_ret_ctrl_tb;
    localparam int CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        ret_req = 1'b0;
    logic [16:0] mem_addr;
    wire  [7:0]  mem_dq;
    logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sram_ret_ctrl #(.ADDR_W(17), .DATA_W(8), .CYC_CLKS(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ret_req(ret_req),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // RAM model: low byte indexes, upper bits kept as tag
    logic [7:0] m_data [256];
    logic [8:0] m_tag  [256];
    logic       m_vld  [256];
    logic [7:0] m_rd;
    logic       m_sel;

    assign m_sel  = !mem_cs1_n && mem_cs2;
    assign m_rd   = (m_vld[mem_addr[7:0]] && m_tag[mem_addr[7:0]] == mem_addr[16:8])
                    ? m_data[mem_addr[7:0]] : 8'hEE;
    assign mem_dq = (m_sel && mem_we_n && !mem_oe_n) ? m_rd : 8'hzz;

    initial begin
        for (int i = 0; i < 256; i++) begin
            m_vld[i]  = 1'b0;
            m_data[i] = '0;
            m_tag[i]  = '0;
        end
    end

    always @(negedge clk) begin
        if (m_sel && !mem_we_n) begin
            m_data[mem_addr[7:0]] = mem_dq;
            m_tag[mem_addr[7:0]]  = mem_addr[16:8];
            m_vld[mem_addr[7:0]]  = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs1_n", 32'(mem_cs1_n), 1);
        chk("R1 cs2", 32'(mem_cs2), 1);
        chk("R1 we_n/oe_n", {30'd0, mem_we_n, mem_oe_n}, 3);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 ready", 32'(req_ready), 1);
    endtask

    task automatic t_write(input logic [16:0] a, input logic [7:0] d);
        int we_low = 0, bad_sel = 0, bad_we = 0, bad_dq = 0, bad_adr = 0, rdy = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        for (int i = 0; i < CYC; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
            end
            if (mem_cs1_n || !mem_cs2 || !mem_oe_n) bad_sel++;
            if (mem_we_n !== ((i == 0) || (i == CYC - 1))) bad_we++;
            if (!mem_we_n) begin
                we_low++;
                if (mem_dq !== d) bad_dq++;
            end
            if (mem_addr !== a) bad_adr++;
            if (req_ready) rdy++;
        end
        chk("R3 write select", bad_sel, 0);
        chk("R3 we_n placement", bad_we, 0);
        chk("R3 we_n low count", we_low, CYC - 2);
        chk("R9 write data on bus", bad_dq, 0);
        chk("R4 addr stable (write)", bad_adr, 0);
        chk("R5 ready low in write", rdy, 0);
        @(negedge clk);
        chk("R3 deselect after write", {30'd0, mem_cs1_n, req_ready}, 3);
    endtask

    task automatic t_read(input logic [16:0] a, input logic [7:0] exp);
        int bad_pins = 0, bad_adr = 0, rdy = 0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        for (int i = 0; i < CYC; i++) begin
            @(negedge clk);
            if (i == 0) begin
                req_valid = 1'b0; req_addr = ~a;
            end
            if (mem_cs1_n || !mem_cs2 || mem_oe_n || !mem_we_n) bad_pins++;
            if (mem_addr !== a) bad_adr++;
            if (req_ready) rdy++;
            if (rd_valid) bad_pins++;
        end
        chk("R2 read pins", bad_pins, 0);
        chk("R4 addr stable (read)", bad_adr, 0);
        chk("R5 ready low in read", rdy, 0);
        @(negedge clk);
        chk("R2 rd_valid", 32'(rd_valid), 1);
        chk("R2 rd_data", 32'(rd_data), 32'(exp));
        chk("R2 deselect after read", 32'(mem_cs1_n), 1);
        @(negedge clk);
        chk("R2 rd_valid pulse", 32'(rd_valid), 0);
    endtask

    task automatic t_retention(input bool_hold);
        int bad = 0, rec = 0, bad_rec = 0;
        ret_req = 1'b1;
        @(negedge clk);
        chk("R6 retain pins", {28'd0, mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n}, 32'b1011);
        chk("R6 ready low", 32'(req_ready), 0);
        if (bool_hold) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'h77;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!mem_cs1_n || mem_cs2 || !mem_we_n || !mem_oe_n || req_ready) bad++;
        end
        chk("R5 held off in retention", bad, 0);
        req_valid = 1'b0;
        ret_req = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 100 && !req_ready; i++) begin
            rec++;
            if (!mem_cs1_n || mem_cs2) bad_rec++;
            @(negedge clk);
        end
        chk("R7 recovery length", rec, CYC);
        chk("R7 deselected in recovery", bad_rec, 0);
        chk("R7 idle after recovery", {30'd0, mem_cs2, req_ready}, 3);
    endtask

    task automatic t_priority();
        int sel = 0;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1FFFF; req_wdata = 8'h33;
        ret_req = 1'b1;
        #0;
        chk("R8 ready low with ret_req", 32'(req_ready), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!mem_cs1_n) sel++;
        end
        chk("R8 no access started", sel, 0);
        chk("R8 in retention", 32'(mem_cs2), 0);
        req_valid = 1'b0;
        ret_req = 1'b0;
        for (int i = 0; i < CYC + 1; i++) @(negedge clk);
        chk("R8 back to idle", 32'(req_ready), 1);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_write(17'h00000, 8'h00);
        t_write(17'h1FFFF, 8'hFF);
        t_write(17'h0AB5A, 8'hA5);
        t_read(17'h0AB5A, 8'hA5);
        t_read(17'h00000, 8'h00);
        t_read(17'h1FFFF, 8'hFF);
        t_write(17'h00000, 8'h5C);
        t_read(17'h00000, 8'h5C);
        t_retention(1'b0);
        t_retention(1'b1);
        t_read(17'h00000, 8'h5C);
        t_read(17'h0AB5A, 8'hA5);
        t_priority();
        t_read(17'h1FFFF, 8'hFF);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule